// File: doc/BRIEF.md
# Multiply-Accumulate Product and Saturation Unit

This block supplies the arithmetic edge of a multiply-accumulate engine. Two jobs pass through it. A product request takes two 32-bit operands and forms the value to be added into an accumulator. It works in one of three number formats: signed integer, unsigned integer, or signed fraction. In the integer formats it detects products that fall outside the 40-bit contribution range. When saturation mode is on, it replaces such a product with a value large enough that the following accumulate is certain to overflow. In fractional format the product drops its low 24 bits, and rounding to nearest with ties to even can optionally be applied.

A saturate request takes a 64-bit accumulator sum produced after the add and limits it to the 48-bit accumulator range. The clamp values depend on the format. The block keeps a sticky overflow flag and one overflow bit per accumulator. The accumulator index named by a saturate request selects which of those bits is set. If the overflow flag is already set when a saturate request arrives, that request also counts as overflowed.

Each request is accepted together with its mode bits on a cycle where `in_valid` is high. Its result appears one clock later.

Top module: `mac_sat_unit`

## Requirements
- R1: A signed product request (mode 2'b00, `op_kind`=0) multiplies the operands as signed two's-complement numbers. If the product lies outside [-2^39, 2^39-1], the sticky flag `v_flag` is set. With `sat_en`=0 the output is the product's low 40 bits, sign-extended from bit 39.
- R2: A signed product that overflows with `sat_en`=1 outputs 2^50 if positive and the bitwise complement of 2^50 if negative.
- R3: An unsigned product request (mode 2'b01) multiplies the operands as unsigned numbers. Any set bit in product bits 63..40 sets `v_flag`. On such an overflow the output is 2^50 with `sat_en`=1. With `sat_en`=0 the output is the product truncated to 40 bits. A product with no overflow is passed unchanged.
- R4: A fractional product request (mode 2'b10, with 2'b11 decoded the same way) multiplies the operands as signed numbers and shifts the product arithmetically right by 24. It never sets `v_flag`. With `round_en`=0 the discarded bits are simply dropped.
- R5: With `round_en`=1 in fractional mode, the shifted value is incremented when the discarded 24 bits exceed 0x800000. It is unchanged when they are below 0x800000. On exactly 0x800000 it is incremented only if the shifted value is odd.
- R6: A signed saturate request (`op_kind`=1, mode 2'b00) flags overflow when `acc_in` differs from its sign extension from bit 47. If the overflow flag is set after the request and `sat_en`=1, the output is 0x000000007FFFFFFF when the bit-47 sign is clear and 0xFFFFFFFF80000000 when it is set. Otherwise the output is `acc_in` sign-extended from bit 47.
- R7: A fractional saturate request uses the same 48-bit overflow test as R6. Its clamp values are 0x00007FFFFFFFFFFF and 0xFFFF800000000000.
- R8: An unsigned saturate request flags overflow if any of bits 63..48 of `acc_in` is set. If the overflow flag is then set, the output with `sat_en`=1 is 0 when `acc_in` > 2^53 and 2^48-1 otherwise. With `sat_en`=0 the output is `acc_in` truncated to 48 bits. If the flag is clear, `acc_in` is passed unchanged.
- R9: `v_flag` is sticky. Once set it stays set until cleared. A saturate request whose overflow flag is set afterwards sets bit `acc_idx` of `pav`. An overflow flag left set by an earlier request makes a later in-range saturate request clamp and mark `pav`.
- R10: `flag_clr` clears `v_flag` and every `pav` bit in any cycle. A request accepted in the same cycle sees the cleared flags, and its own overflow still sets them.
- R11: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. `out_data` and the flags change only at that edge, and `out_data` holds its value while no request is accepted.
- R12: Synchronous reset drives `out_valid` low and clears `out_data`, `v_flag` and `pav`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request accepted this cycle |
| op_kind | input | 1 | 0 = product request, 1 = saturate request |
| mode | input | 2 | 00 signed integer, 01 unsigned integer, 1x fractional |
| sat_en | input | 1 | Saturation mode |
| round_en | input | 1 | Fractional rounding enable |
| op_a | input | 32 | First multiplier operand |
| op_b | input | 32 | Second multiplier operand |
| acc_in | input | 64 | Accumulator sum to saturate |
| acc_idx | input | IDX_W (2) | Accumulator index for the overflow bit |
| flag_clr | input | 1 | Clear the sticky flag and all per-accumulator bits |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Product contribution or saturated accumulator |
| v_flag | output | 1 | Sticky overflow flag |
| pav | output | NACC (4) | Per-accumulator overflow bits |

## Verification
The sweeps target the edges of each range. One is a signed product of exactly 2^39, which overflows in signed mode but not in unsigned mode. Others are accumulator values one step on either side of ±2^47, 2^48 and 2^53. A design that compared against the wrong bit would either wrap these values silently or clamp values that are in range. The fractional sweep includes discarded fields just below, exactly at, and just above one half, with both even and odd quotients. Truncation or round-half-up would then show up as an off-by-one in the last bit.

Saturate requests are repeated with the sticky flag left set by an earlier signed overflow. A unit that clamped only on its own overflow would pass those in-range sums through unchanged, and one that ignored the index would set the wrong `pav` bit.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OP_W      = 32;
    localparam int PROD_W    = 2 * OP_W;
    localparam int CONTRIB_W = 40;
    localparam int ACC_W     = 48;
    localparam int FRAC_SH   = 24;

    localparam logic [PROD_W-1:0] PROD_FORCE  = 64'h0004_0000_0000_0000;
    localparam logic [PROD_W-1:0] U_ZERO_LIM  = 64'h0020_0000_0000_0000;
    localparam logic [PROD_W-1:0] U_ACC_MAX   = 64'h0000_FFFF_FFFF_FFFF;
    localparam logic [PROD_W-1:0] SINT_HI     = 64'h0000_0000_7FFF_FFFF;
    localparam logic [PROD_W-1:0] SINT_LO     = 64'hFFFF_FFFF_8000_0000;
    localparam logic [PROD_W-1:0] FRAC_HI     = 64'h0000_7FFF_FFFF_FFFF;
    localparam logic [PROD_W-1:0] FRAC_LO     = 64'hFFFF_8000_0000_0000;
    localparam logic [FRAC_SH-1:0] HALF_LSB   = 24'h80_0000;

    typedef enum logic [1:0] {
        MODE_SINT     = 2'b00,
        MODE_UINT     = 2'b01,
        MODE_FRAC     = 2'b10,
        MODE_FRAC_ALT = 2'b11
    } mac_mode_e;

    typedef struct packed {
        logic      sat_en;
        logic      round_en;
        mac_mode_e mode;
    } mac_ctrl_t;

    typedef struct packed {
        logic [PROD_W-1:0] value;
        logic              ovf;
    } mac_res_t;

    function automatic logic [PROD_W-1:0] sext_contrib(input logic [PROD_W-1:0] v);
        return {{(PROD_W-CONTRIB_W){v[CONTRIB_W-1]}}, v[CONTRIB_W-1:0]};
    endfunction

    function automatic logic [PROD_W-1:0] sext_acc(input logic [PROD_W-1:0] v);
        return {{(PROD_W-ACC_W){v[ACC_W-1]}}, v[ACC_W-1:0]};
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
(
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  mac_ctrl_t       ctrl,
    output mac_res_t        res
);

    logic signed [PROD_W-1:0] s_a, s_b, s_prod;
    logic [PROD_W-1:0]        u_prod;
    logic [PROD_W-1:0]        wrapped;
    logic [PROD_W-1:0]        shifted;
    logic [FRAC_SH-1:0]       dropped;
    logic                     bump;

    always_comb begin
        s_a     = {{OP_W{op_a[OP_W-1]}}, op_a};
        s_b     = {{OP_W{op_b[OP_W-1]}}, op_b};
        s_prod  = s_a * s_b;
        u_prod  = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};
        wrapped = sext_contrib(s_prod);
        shifted = {{FRAC_SH{s_prod[PROD_W-1]}}, s_prod[PROD_W-1:FRAC_SH]};
        dropped = s_prod[FRAC_SH-1:0];
        bump    = ctrl.round_en &&
                  ((dropped > HALF_LSB) || ((dropped == HALF_LSB) && shifted[0]));
        res     = '0;
        case (ctrl.mode)
            MODE_SINT: begin
                res.ovf   = (wrapped != s_prod);
                res.value = (res.ovf && ctrl.sat_en)
                          ? (s_prod[PROD_W-1] ? ~PROD_FORCE : PROD_FORCE)
                          : wrapped;
            end
            MODE_UINT: begin
                res.ovf   = |u_prod[PROD_W-1:CONTRIB_W];
                res.value = (res.ovf && ctrl.sat_en)
                          ? PROD_FORCE
                          : {{(PROD_W-CONTRIB_W){1'b0}}, u_prod[CONTRIB_W-1:0]};
            end
            default: begin
                res.ovf   = 1'b0;
                res.value = shifted + PROD_W'(bump);
            end
        endcase
    end

endmodule

// File: rtl/mac_acc_sat.sv
module mac_acc_sat
    import mac_pkg::*;
(
    input  logic [PROD_W-1:0] acc_in,
    input  mac_mode_e         mode,
    input  logic              sat_en,
    input  logic              v_prior,
    output mac_res_t          res,
    output logic              v_after
);

    logic [PROD_W-1:0] narrowed;
    logic              s_ovf, u_ovf;

    always_comb begin
        narrowed = sext_acc(acc_in);
        s_ovf    = (narrowed != acc_in);
        u_ovf    = |acc_in[PROD_W-1:ACC_W];
        res      = '0;
        res.ovf  = (mode == MODE_UINT) ? u_ovf : s_ovf;
        v_after  = v_prior | res.ovf;
        case (mode)
            MODE_UINT: begin
                if (!v_after)
                    res.value = acc_in;
                else if (sat_en)
                    res.value = (acc_in > U_ZERO_LIM) ? '0 : U_ACC_MAX;
                else
                    res.value = {{(PROD_W-ACC_W){1'b0}}, acc_in[ACC_W-1:0]};
            end
            MODE_SINT: begin
                res.value = (v_after && sat_en)
                          ? (narrowed[PROD_W-1] ? SINT_LO : SINT_HI)
                          : narrowed;
            end
            default: begin
                res.value = (v_after && sat_en)
                          ? (narrowed[PROD_W-1] ? FRAC_LO : FRAC_HI)
                          : narrowed;
            end
        endcase
    end

endmodule

// File: rtl/mac_flags.sv
module mac_flags #(
    parameter int NACC  = 4,
    parameter int IDX_W = $clog2(NACC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             set_v,
    input  logic             set_pav,
    input  logic [IDX_W-1:0] idx,
    output logic             v_q,
    output logic [NACC-1:0]  pav_q
);

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= (v_q & ~clr) | set_v;
    end

    for (genvar i = 0; i < NACC; i++) begin : g_pav
        always_ff @(posedge clk) begin
            if (rst) pav_q[i] <= 1'b0;
            else     pav_q[i] <= (pav_q[i] & ~clr) | (set_pav && (idx == IDX_W'(i)));
        end
    end

    assert_v_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (v_q && !clr) |=> v_q);

    assert_pav_implies_v_R9: assert property (@(posedge clk) disable iff (rst)
        (|pav_q) |-> v_q);

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_v && !set_pav) |=> (!v_q && (pav_q == '0)));

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int NACC  = 4,
    parameter int IDX_W = $clog2(NACC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_kind,
    input  logic [1:0]        mode,
    input  logic              sat_en,
    input  logic              round_en,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [PROD_W-1:0] acc_in,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              flag_clr,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_data,
    output logic              v_flag,
    output logic [NACC-1:0]   pav
);

    mac_ctrl_t ctrl;
    mac_res_t  prod_res, acc_res;
    logic      v_prior, v_after, set_v, set_pav;

    always_comb begin
        ctrl.mode     = mac_mode_e'(mode);
        ctrl.sat_en   = sat_en;
        ctrl.round_en = round_en;
        v_prior       = v_flag & ~flag_clr;
        set_v         = in_valid & (op_kind ? acc_res.ovf : prod_res.ovf);
        set_pav       = in_valid & op_kind & v_after;
    end

    mac_product u_product (
        .op_a (op_a),
        .op_b (op_b),
        .ctrl (ctrl),
        .res  (prod_res)
    );

    mac_acc_sat u_acc_sat (
        .acc_in  (acc_in),
        .mode    (ctrl.mode),
        .sat_en  (sat_en),
        .v_prior (v_prior),
        .res     (acc_res),
        .v_after (v_after)
    );

    mac_flags #(.NACC(NACC), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr     (flag_clr),
        .set_v   (set_v),
        .set_pav (set_pav),
        .idx     (acc_idx),
        .v_q     (v_flag),
        .pav_q   (pav)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= op_kind ? acc_res.value : prod_res.value;
        end
    end

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    assert_uint_range_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_kind) && ($past(mode) == 2'b01))
        |-> (out_data[PROD_W-1:ACC_W] == '0));

    assert_sint_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && v_flag && $past(op_kind) && ($past(mode) == 2'b00) && $past(sat_en))
        |-> ((out_data == SINT_HI) || (out_data == SINT_LO)));

endmodule

// File: tb/mac_sat_unit_bench.sv
`timescale 1ns/1ps
module mac_sat_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, op_kind, sat_en, round_en, flag_clr;
    logic [1:0]  mode;
    logic [31:0] op_a, op_b;
    logic [63:0] acc_in;
    logic [1:0]  acc_idx;
    logic        out_valid, v_flag;
    logic [63:0] out_data;
    logic [3:0]  pav;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mac_sat_unit u_mac_sat_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_kind(op_kind), .mode(mode),
        .sat_en(sat_en), .round_en(round_en), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .acc_idx(acc_idx), .flag_clr(flag_clr),
        .out_valid(out_valid), .out_data(out_data), .v_flag(v_flag), .pav(pav)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; the result is visible on return.
    task automatic do_op(input bit kind, input logic [1:0] m, input bit sat, input bit rnd,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [63:0] acc, input logic [1:0] idx, input bit clr);
        in_valid = 1'b1; op_kind = kind; mode = m; sat_en = sat; round_en = rnd;
        op_a = a; op_b = b; acc_in = acc; acc_idx = idx; flag_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
    endtask

    function automatic logic [64:0] exp_prod(input logic [1:0] m, input bit sat, input bit rnd,
                                             input logic [31:0] a, input logic [31:0] b);
        longint      sp, q, r;
        logic [63:0] up;
        bit          ovf;
        logic [63:0] val;
        sp  = longint'($signed(a)) * longint'($signed(b));
        up  = {32'd0, a} * {32'd0, b};
        ovf = 1'b0;
        if (m == 2'b00) begin
            ovf = (sp > 64'sh7F_FFFF_FFFF) || (sp < -64'sh80_0000_0000);
            if (ovf && sat) val = (sp < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
            else begin q = (sp <<< 24) >>> 24; val = q; end
        end else if (m == 2'b01) begin
            ovf = (up >= 64'h100_0000_0000);
            val = (ovf && sat) ? (64'd1 << 50) : (up & 64'hFF_FFFF_FFFF);
        end else begin
            q = sp >>> 24;
            r = sp & 64'hFF_FFFF;
            if (rnd) begin
                if (r > 64'h80_0000) q = q + 1;
                else if (r == 64'h80_0000) q = q + (q & 1);
            end
            val = q;
        end
        return {ovf, val};
    endfunction

    function automatic logic [64:0] exp_sat(input logic [1:0] m, input bit sat, input bit prior,
                                            input logic [63:0] acc);
        longint      s;
        bit          ovf, vn;
        logic [63:0] val;
        s = (longint'(acc) <<< 16) >>> 16;
        if (m == 2'b01) begin
            ovf = (acc >= 64'h1_0000_0000_0000);
            vn  = prior | ovf;
            if (!vn) val = acc;
            else if (sat) val = (acc > 64'h20_0000_0000_0000) ? 64'd0 : 64'hFFFF_FFFF_FFFF;
            else val = acc & 64'hFFFF_FFFF_FFFF;
        end else begin
            ovf = (s != longint'(acc));
            vn  = prior | ovf;
            val = s;
            if (vn && sat) begin
                if (m == 2'b00) val = (s < 0) ? 64'hFFFF_FFFF_8000_0000 : 64'h7FFF_FFFF;
                else            val = (s < 0) ? 64'hFFFF_8000_0000_0000 : 64'h7FFF_FFFF_FFFF;
            end
        end
        return {vn, val};
    endfunction

    logic [31:0] opv [12];
    logic [63:0] accv [14];

    initial begin
        opv = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0008_0000,
                32'h0010_0000, 32'h0080_0000, 32'h0180_0000, 32'h0080_0001, 32'h007F_FFFF,
                32'hFFF0_0003};
        accv = '{64'h0, 64'h1, 64'h7FFF_FFFF_FFFF, 64'h8000_0000_0000,
                 64'hFFFF_8000_0000_0000, 64'hFFFF_7FFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF,
                 64'h1_0000_0000_0000, 64'h4_0000_0000_0000, 64'h20_0000_0000_0000,
                 64'h20_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678,
                 64'hFFFF_FFFF_FFFF_FFFB};
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [64:0] e;
        logic [63:0] held;
        rst = 1'b1; in_valid = 1'b0; op_kind = 1'b0; mode = 2'b00; sat_en = 1'b0;
        round_en = 1'b0; op_a = '0; op_b = '0; acc_in = '0; acc_idx = '0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 out_valid", 64'(out_valid), 64'd0);
        chk("R12 out_data", out_data, 64'd0);
        chk("R12 v_flag", 64'(v_flag), 64'd0);
        chk("R12 pav", 64'(pav), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4 R5 product sweep
        for (int m = 0; m < 3; m++)
            for (int s = 0; s < 2; s++)
                for (int r = 0; r < 2; r++)
                    for (int i = 0; i < 12; i++)
                        for (int j = 0; j < 12; j++) begin
                            e = exp_prod(2'(m), s[0], r[0], opv[i], opv[j]);
                            do_op(1'b0, 2'(m), s[0], r[0], opv[i], opv[j], '0, '0, 1'b1);
                            if (m == 0)      chk("R1/R2 signed product", out_data, e[63:0]);
                            else if (m == 1) chk("R3 unsigned product", out_data, e[63:0]);
                            else if (r == 1) chk("R5 rounded fraction", out_data, e[63:0]);
                            else             chk("R4 fraction", out_data, e[63:0]);
                            chk("R1/R3/R4 overflow flag", 64'(v_flag), 64'(e[64]));
                        end

        // R4 encoding 2'b11 decodes as fractional
        do_op(1'b0, 2'b11, 1'b0, 1'b1, 32'h0180_0000, 32'h1, '0, '0, 1'b1);
        chk("R4 mode 11 fraction", out_data, 64'd2);

        // R6 R7 R8 R9 saturate sweep, with and without a prior overflow
        for (int m = 0; m < 3; m++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 2; p++)
                    for (int k = 0; k < 14; k++) begin
                        logic [1:0] idx;
                        idx = 2'(k + m);
                        if (p == 1)
                            do_op(1'b0, 2'b00, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, '0, '0, 1'b1);
                        e = exp_sat(2'(m), s[0], p[0], accv[k]);
                        do_op(1'b1, 2'(m), s[0], 1'b0, '0, '0, accv[k], idx, (p == 0));
                        if (m == 0)      chk("R6 signed saturate", out_data, e[63:0]);
                        else if (m == 1) chk("R8 unsigned saturate", out_data, e[63:0]);
                        else             chk("R7 fractional saturate", out_data, e[63:0]);
                        chk("R9 v after saturate", 64'(v_flag), 64'(e[64]));
                        chk("R9 pav index", 64'(pav), e[64] ? (64'd1 << idx) : 64'd0);
                    end

        // R9 sticky across a non-overflowing product
        do_op(1'b0, 2'b01, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, '0, 1'b1);
        do_op(1'b0, 2'b00, 1'b0, 1'b0, 32'h3, 32'h5, '0, '0, 1'b0);
        chk("R9 sticky v", 64'(v_flag), 64'd1);
        chk("R1 small product", out_data, 64'd15);

        // R10 clear without a request, then alone
        do_op(1'b1, 2'b10, 1'b1, 1'b0, '0, '0, 64'h1234, 2'd3, 1'b0);
        chk("R10 pav before clear", 64'(pav), 64'h8);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R10 v cleared", 64'(v_flag), 64'd0);
        chk("R10 pav cleared", 64'(pav), 64'd0);

        // R11 idle behaviour
        do_op(1'b0, 2'b00, 1'b0, 1'b0, 32'h7, 32'h9, '0, '0, 1'b0);
        chk("R11 out_valid after request", 64'(out_valid), 64'd1);
        held = out_data;
        @(negedge clk);
        chk("R11 out_valid idle", 64'(out_valid), 64'd0);
        op_a = 32'h55; op_b = 32'h66;
        @(negedge clk);
        chk("R11 out_data held", out_data, held);
        chk("R11 held value", held, 64'd63);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule